// File: doc/BRIEF.md
# Data-Space Access Steering with On-Chip RAM

This block sits between the data-access port of an 8-bit microcontroller core and the storage behind it. For every request it names one destination: the lower internal RAM, the upper internal RAM, the special function register space, an on-chip expanded RAM, or the external data bus. It also produces the address local to that destination. It decides from the access address, the addressing kind of the instruction (direct, indirect, or an external-data move through an 8-bit pointer or through the 16-bit data pointer) and a single expanded-RAM disable bit.

The block holds the internal storage itself: two 128-byte halves of internal RAM and a 768-byte expanded RAM, 1024 bytes in all. The upper internal half and the register space share the same 8-bit addresses. Only the addressing kind picks between them. External-data moves that land in the low expanded window are served on chip, and the external-bus enable stays low for them. Register contents, instruction decoding and external bus timing are left to neighbouring blocks.

Top module: `dmem_steer`

## Requirements
- R1: With `acc_mode` 0 (direct) or 1 (indirect) and `acc_addr[7:0]` in 00h–7Fh, `tgt` is 1 (lower RAM) and `loc_addr` equals `acc_addr[7:0]`. Both modes reach the same storage.
- R2: With `acc_mode` 1 and `acc_addr[7:0]` in 80h–FFh, `tgt` is 2 (upper RAM) and `loc_addr` equals `acc_addr[7:0]` minus 80h.
- R3: With `acc_mode` 0 and `acc_addr[7:0]` in 80h–FFh, `tgt` is 3 (register space) and `loc_addr` equals `acc_addr[7:0]`. No internal storage is written, and no read data is returned. A direct write to 90h leaves the upper-RAM byte at 90h unchanged.
- R4: Direct and indirect accesses ignore `acc_addr[15:8]`.
- R5: With `acc_mode` 2 or 3, the expanded RAM enabled, and an effective address below 300h, `tgt` is 4 (expanded RAM), `loc_addr` equals the effective address, and `ext_en` is 0.
- R6: With `acc_mode` 2 or 3, `tgt` is 5 (external bus), `ext_en` is 1 and `loc_addr` equals the effective address when the effective address is 300h or higher, or when the expanded RAM is disabled. No internal storage changes.
- R7: In `acc_mode` 2 the effective address is `{8'h00, acc_addr[7:0]}`. In `acc_mode` 3 it is the full `acc_addr`.
- R8: A read to an internal store (`tgt` 1, 2 or 4) returns the byte on `rdata` with `rvalid` high one clock after the request. A write commits at the request's clock edge and is visible to the next read.
- R9: The expanded-RAM disable bit resets to 0, meaning the expanded RAM is enabled. It loads `cfg_xram_off` on a clock edge where `cfg_we` is high.
- R10: With `acc_req` low, `tgt` is 0, `ext_en` is 0 and `loc_addr` is 0. In the next cycle `rvalid` is 0 and `rdata` is 0. `rdata` is also 0 in any cycle where `rvalid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_req | input | 1 | Access request this cycle |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_mode | input | 2 | 0 direct, 1 indirect, 2 external move via 8-bit pointer, 3 external move via data pointer |
| acc_addr | input | 16 | Access address |
| acc_wdata | input | 8 | Write data |
| cfg_we | input | 1 | Load the expanded-RAM disable bit |
| cfg_xram_off | input | 1 | New value of the disable bit |
| tgt | output | 3 | Destination code (0 none, 1 lower, 2 upper, 3 registers, 4 expanded, 5 external) |
| loc_addr | output | 16 | Address within the destination |
| ext_en | output | 1 | External data bus cycle requested |
| rdata | output | 8 | Read data, one clock after the request |
| rvalid | output | 1 | `rdata` carries internal read data |

## Verification
The bench builds the block with its default parameters: 256 bytes of internal RAM split at 80h, 768 bytes of expanded RAM, and a 16-bit address. With these values the 80h boundary, the 2FFh/300h edge of the expanded window and the top of the 64 KB external space can all be hit directly. Every internal byte is filled first, so a random mix of kinds, addresses and disable-bit changes can read any location against the bench's own model. A direct write at 90h followed by an indirect read of 90h shows that the register space and the upper RAM are separate.

// File: rtl/dmem_pkg.sv
package dmem_pkg;

  typedef enum logic [1:0] {
    MODE_DIRECT   = 2'd0,
    MODE_INDIRECT = 2'd1,
    MODE_XPTR8    = 2'd2,
    MODE_XDPTR    = 2'd3
  } acc_mode_e;

  typedef enum logic [2:0] {
    TGT_NONE = 3'd0,
    TGT_LOW  = 3'd1,
    TGT_HIGH = 3'd2,
    TGT_SFR  = 3'd3,
    TGT_XRAM = 3'd4,
    TGT_EXT  = 3'd5
  } tgt_e;

  function automatic logic is_movx(acc_mode_e m);
    return (m == MODE_XPTR8) || (m == MODE_XDPTR);
  endfunction

  function automatic logic is_store(tgt_e t);
    return (t == TGT_LOW) || (t == TGT_HIGH) || (t == TGT_XRAM);
  endfunction

endpackage

// File: rtl/dmem_decode.sv
module dmem_decode
  import dmem_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int IRAM_BYTES = 256,
  parameter int XRAM_BYTES = 768
) (
  input  logic              req,
  input  acc_mode_e         mode,
  input  logic [ADDR_W-1:0] addr,
  input  logic              xram_off,
  output tgt_e              tgt,
  output logic [ADDR_W-1:0] loc,
  output logic              ext_en
);

  localparam int HALF = IRAM_BYTES / 2;
  localparam int IW   = $clog2(IRAM_BYTES);

  // Effective external-space address: an 8-bit pointer zero-extends.
  function automatic logic [ADDR_W-1:0] eff_addr(acc_mode_e m, logic [ADDR_W-1:0] a);
    if (m == MODE_XPTR8) return {{(ADDR_W-8){1'b0}}, a[7:0]};
    return a;
  endfunction

  // Internal-space offset: only the low byte takes part.
  function automatic logic [IW-1:0] ioff(logic [ADDR_W-1:0] a);
    return a[IW-1:0];
  endfunction

  logic [ADDR_W-1:0] eff;
  logic [IW-1:0]     off;
  logic              in_lower;
  logic              in_xwin;

  assign eff      = eff_addr(mode, addr);
  assign off      = ioff(addr);
  assign in_lower = (int'(off) < HALF);
  assign in_xwin  = (int'(eff) < XRAM_BYTES);

  always_comb begin
    tgt    = TGT_NONE;
    loc    = '0;
    ext_en = 1'b0;
    if (req) begin
      unique case (mode)
        MODE_DIRECT, MODE_INDIRECT: begin
          if (in_lower) begin
            tgt = TGT_LOW;
            loc = ADDR_W'(off);
          end else if (mode == MODE_INDIRECT) begin
            tgt = TGT_HIGH;
            loc = ADDR_W'(off) - ADDR_W'(HALF);
          end else begin
            tgt = TGT_SFR;
            loc = ADDR_W'(off);
          end
        end
        default: begin
          loc = eff;
          if (!xram_off && in_xwin) begin
            tgt = TGT_XRAM;
          end else begin
            tgt    = TGT_EXT;
            ext_en = 1'b1;
          end
        end
      endcase
    end
  end

  // Register space is only ever reached by direct addressing.
  always_comb begin
    if (tgt == TGT_SFR) assert_sfr_direct_R3: assert (mode == MODE_DIRECT);
  end

  // An on-chip expanded access never requests the external bus.
  always_comb begin
    if (tgt == TGT_XRAM) assert_xram_quiet_R5: assert (!ext_en && is_movx(mode));
  end

endmodule

// File: rtl/dmem_bank.sv
module dmem_bank #(
  parameter int DEPTH  = 128,
  parameter int DATA_W = 8,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic              re,
  input  logic [AW-1:0]     addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    if (re) rdata <= mem[addr];
  end

endmodule

// File: rtl/dmem_steer.sv
module dmem_steer
  import dmem_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 8,
  parameter int IRAM_BYTES = 256,
  parameter int XRAM_BYTES = 768
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_req,
  input  logic              acc_wr,
  input  logic [1:0]        acc_mode,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [DATA_W-1:0] acc_wdata,
  input  logic              cfg_we,
  input  logic              cfg_xram_off,
  output logic [2:0]        tgt,
  output logic [ADDR_W-1:0] loc_addr,
  output logic              ext_en,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid
);

  localparam int HALF = IRAM_BYTES / 2;
  localparam int HW   = $clog2(HALF);
  localparam int XW   = $clog2(XRAM_BYTES);
  localparam int NB   = 3;

  acc_mode_e mode;
  tgt_e      tgt_d;
  tgt_e      src_q;
  logic      xram_off_q;
  logic      hit_store;
  logic      do_rd;
  logic [NB-1:0]     bank_we;
  logic [NB-1:0]     bank_re;
  logic [DATA_W-1:0] bank_rd [NB];

  assign mode = acc_mode_e'(acc_mode);

  dmem_decode #(
    .ADDR_W(ADDR_W), .IRAM_BYTES(IRAM_BYTES), .XRAM_BYTES(XRAM_BYTES)
  ) u_decode (
    .req(acc_req), .mode(mode), .addr(acc_addr), .xram_off(xram_off_q),
    .tgt(tgt_d), .loc(loc_addr), .ext_en(ext_en)
  );

  assign tgt       = tgt_d;
  assign hit_store = is_store(tgt_d);
  assign do_rd     = hit_store && !acc_wr;

  // One enable per store, in order lower, upper, expanded.
  assign bank_we = {3{acc_wr}} & {tgt_d == TGT_XRAM, tgt_d == TGT_HIGH, tgt_d == TGT_LOW};
  assign bank_re = {3{!acc_wr}} & {tgt_d == TGT_XRAM, tgt_d == TGT_HIGH, tgt_d == TGT_LOW};

  dmem_bank #(.DEPTH(HALF), .DATA_W(DATA_W)) u_low (
    .clk(clk), .we(bank_we[0]), .re(bank_re[0]), .addr(loc_addr[HW-1:0]),
    .wdata(acc_wdata), .rdata(bank_rd[0])
  );

  dmem_bank #(.DEPTH(HALF), .DATA_W(DATA_W)) u_high (
    .clk(clk), .we(bank_we[1]), .re(bank_re[1]), .addr(loc_addr[HW-1:0]),
    .wdata(acc_wdata), .rdata(bank_rd[1])
  );

  dmem_bank #(.DEPTH(XRAM_BYTES), .DATA_W(DATA_W)) u_xram (
    .clk(clk), .we(bank_we[2]), .re(bank_re[2]), .addr(loc_addr[XW-1:0]),
    .wdata(acc_wdata), .rdata(bank_rd[2])
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      xram_off_q <= 1'b0;
      src_q      <= TGT_NONE;
      rvalid     <= 1'b0;
    end else begin
      if (cfg_we) xram_off_q <= cfg_xram_off;
      src_q  <= do_rd ? tgt_d : TGT_NONE;
      rvalid <= do_rd;
    end
  end

  always_comb begin
    unique case (src_q)
      TGT_LOW:  rdata = bank_rd[0];
      TGT_HIGH: rdata = bank_rd[1];
      TGT_XRAM: rdata = bank_rd[2];
      default:  rdata = '0;
    endcase
  end

  assert_single_bank_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bank_we | bank_re));

  assert_ext_only_movx_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ext_en |-> (tgt_d == TGT_EXT) && is_movx(mode) && !bank_we[2]);

  assert_read_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_req && !acc_wr && hit_store) |=> rvalid);

  assert_rvalid_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid |-> $past(acc_req && !acc_wr));

  assert_xram_reset_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> !xram_off_q);

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_req |-> (tgt_d == TGT_NONE) && !ext_en && (bank_we == '0));

endmodule

// File: tb/dmem_steer_tb.sv
module dmem_steer_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        acc_req, acc_wr, cfg_we, cfg_xram_off;
  logic [1:0]  acc_mode;
  logic [15:0] acc_addr;
  logic [7:0]  acc_wdata;
  logic [2:0]  tgt;
  logic [15:0] loc_addr;
  logic        ext_en, rvalid;
  logic [7:0]  rdata;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  int m_low[128];
  int m_high[128];
  int m_x[768];
  bit m_off;
  bit exp_rv;
  int exp_rd;

  always #10 clk = ~clk;

  dmem_steer u_dut (
    .clk(clk), .rst_n(rst_n), .acc_req(acc_req), .acc_wr(acc_wr),
    .acc_mode(acc_mode), .acc_addr(acc_addr), .acc_wdata(acc_wdata),
    .cfg_we(cfg_we), .cfg_xram_off(cfg_xram_off), .tgt(tgt),
    .loc_addr(loc_addr), .ext_en(ext_en), .rdata(rdata), .rvalid(rvalid)
  );

  task automatic check(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // One clock of stimulus; checks the combinational outputs for this
  // request and the read result of the previous one.
  task automatic cyc(bit req, bit wr, int mode, int addr, int wd,
                     bit cwe = 0, bit cval = 0);
    int et, el, ee, eff, a;
    string tag;
    @(negedge clk);
    acc_req = req; acc_wr = wr; acc_mode = 2'(mode);
    acc_addr = 16'(addr); acc_wdata = 8'(wd);
    cfg_we = cwe; cfg_xram_off = cval;
    #1;
    check("R8", "rvalid", int'(rvalid), int'(exp_rv));
    check(exp_rv ? "R8" : "R10", "rdata", int'(rdata), exp_rv ? exp_rd : 0);
    a   = addr & 8'hFF;
    eff = (mode == 2) ? a : (addr & 16'hFFFF);
    et = 0; el = 0; ee = 0; tag = "R10";
    if (req) begin
      if (mode < 2) begin
        tag = (addr > 255) ? "R4" : "R1";
        if (a < 128) begin et = 1; el = a; end
        else if (mode == 1) begin et = 2; el = a - 128; if (addr <= 255) tag = "R2"; end
        else begin et = 3; el = a; if (addr <= 255) tag = "R3"; end
      end else begin
        tag = (mode == 2) ? "R7" : "R5";
        el = eff;
        if (!m_off && eff < 768) et = 4;
        else begin et = 5; ee = 1; tag = "R6"; end
      end
    end
    check(tag, "tgt", int'(tgt), et);
    check(tag, "loc_addr", int'(loc_addr), el);
    check(tag, "ext_en", int'(ext_en), ee);
    exp_rv = 0; exp_rd = 0;
    if (req && (et == 1 || et == 2 || et == 4)) begin
      if (wr) begin
        if (et == 1) m_low[el] = wd & 255;
        else if (et == 2) m_high[el] = wd & 255;
        else m_x[el] = wd & 255;
      end else begin
        exp_rv = 1;
        exp_rd = (et == 1) ? m_low[el] : (et == 2) ? m_high[el] : m_x[el];
      end
    end
    if (cwe) m_off = cval;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 0; acc_req = 0; acc_wr = 0; acc_mode = 0; acc_addr = 0;
    acc_wdata = 0; cfg_we = 0; cfg_xram_off = 0;
    m_off = 0; exp_rv = 0; exp_rd = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    #1;
    check("R10", "reset rvalid", int'(rvalid), 0);
    check("R10", "reset tgt", int'(tgt), 0);
    // R9: after reset a movx at 010h is on chip
    cyc(1, 0, 3, 16'h0010, 0);
    check("R9", "reset xram enabled ext_en", int'(ext_en), 0);
    cyc(0, 0, 0, 0, 0);

    // Fill every store: R1 lower, R2 upper, R5 expanded
    for (int i = 0; i < 128; i++) cyc(1, 1, 1, i, i ^ 8'h5A);
    for (int i = 128; i < 256; i++) cyc(1, 1, 1, i, i ^ 8'hC3);
    for (int i = 0; i < 768; i++) cyc(1, 1, 3, i, (i * 7 + 3) & 255);

    // R1: direct read of lower RAM written indirectly
    cyc(1, 0, 0, 16'h0011, 0);
    cyc(1, 0, 0, 16'h007F, 0);
    // R2/R3: boundary 80h both ways
    cyc(1, 0, 1, 16'h0080, 0);
    cyc(1, 0, 0, 16'h0080, 0);
    // R3: direct write at 90h then indirect read of 90h
    cyc(1, 1, 0, 16'h0090, 8'hEE);
    cyc(1, 0, 1, 16'h0090, 0);
    cyc(1, 0, 0, 16'h0090, 0);
    // R4: upper address byte ignored
    cyc(1, 0, 0, 16'hAB20, 0);
    cyc(1, 0, 1, 16'h77C4, 0);
    cyc(1, 1, 1, 16'hFF05, 8'h31);
    cyc(1, 0, 0, 16'h0005, 0);
    // R7: 8-bit pointer drops the upper byte
    cyc(1, 0, 2, 16'h12FF, 0);
    cyc(1, 1, 2, 16'h0240, 8'h9D);
    cyc(1, 0, 3, 16'h0040, 0);
    // R5/R6: window edge
    cyc(1, 0, 3, 16'h02FF, 0);
    cyc(1, 1, 3, 16'h0300, 8'h11);
    cyc(1, 0, 3, 16'hFFFF, 0);
    cyc(1, 0, 3, 16'h0000, 0);
    // R9/R6: disable expanded RAM, then writes go out
    cyc(0, 0, 0, 0, 0, 1, 1);
    cyc(1, 1, 3, 16'h0020, 8'h00);
    cyc(1, 1, 2, 16'h0021, 8'h00);
    cyc(1, 0, 3, 16'h0000, 0);
    cyc(0, 0, 0, 0, 0, 1, 0);
    cyc(1, 0, 3, 16'h0020, 0);
    cyc(1, 0, 3, 16'h0021, 0);
    // R10: idle cycles
    cyc(0, 1, 1, 16'h0033, 8'h44);
    cyc(0, 0, 0, 0, 0);
    cyc(1, 0, 1, 16'h0033, 0);

    // Mixed random traffic, R8 timing throughout
    for (int k = 0; k < 3000; k++) begin
      int md, ad;
      bit cw;
      md = $urandom_range(0, 3);
      ad = (md == 3) ? ($urandom_range(0, 3) == 0 ? $urandom_range(0, 65535)
                                                  : $urandom_range(0, 900))
                     : $urandom_range(0, 65535);
      cw = ($urandom_range(0, 40) == 0);
      cyc($urandom_range(0, 7) != 0, $urandom_range(0, 1), md, ad,
          $urandom_range(0, 255), cw, cw ? ($urandom_range(0, 2) == 0) : 1'b0);
    end
    cyc(0, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule